// File: doc/BRIEF.md
# PCM Receive Deserializer with Robbed-Bit Signaling Extraction

This block sits on the receive side of a digital voice channel. It takes a serial PCM line and collects each 8-bit companded word while a receive sync window is open. It expands the word to a 13-bit sign-magnitude linear code and keeps that code in a latch, which drives a downstream DAC without interruption until the next complete word replaces it. The whole block runs on the receive bit clock and needs no master clock.

A 12-frame counter moves forward once per word, when sync falls. In frames 6 and 12, which are the signaling frames, the eighth bit of the word carries signaling and not voice. The block stores that bit in the SigA or the SigB latch, as the A/B select input chooses. It decodes the remaining seven bits with bit 8 forced to zero and raises a half-step flag, so that the DAC can add half a step of offset. A superframe-alignment input puts the counter back to frame 1. A law-select input chooses between mu-law and A-law expansion.

The serial capture is a three-state machine. IDLE waits for sync. In IDLE, sync high takes the first bit and the transition *start* goes to SHIFT. In SHIFT, sync high takes further bits. The transition *fill* goes to FULL on the eighth bit. The transition *abort* returns to IDLE if sync drops first. In FULL, clocks with sync high are ignored. The transition *commit* returns to IDLE when sync drops, and it delivers the word.

Top module: `pcm_rx_deser`

## Requirements
- R1: While reset is asserted and after it is released, `lin_o`, `half_step_o`, `sig_a_o` and `sig_b_o` are 0, and the frame counter is at frame 1.
- R2: On each rising clock edge with `rx_sync_i` high, one bit is taken from `rx_data_i`. The bits arrive most significant first. The first bit is the code's sign bit, and the eighth bit is the code's bit 0.
- R3: After the eighth bit of a window, further clocks with sync high have no effect on the decoded word.
- R4: If sync falls before 8 bits have been taken, the word is discarded and all four outputs keep their values. The frame counter still advances.
- R5: The outputs update at the first rising edge that samples sync low after a complete word. They then hold through idle cycles until the next complete word.
- R6: When `mu_law_i` is 0 (A-law), the code c is used as received. The sign is c[7], the segment is s = c[6:4] and the step is t = c[3:0]. `lin_o[12]` equals c[7]. The magnitude `lin_o[11:0]` is 2t+1 when s = 0, and (2t+33)·2^(s-1) otherwise.
- R7: When `mu_law_i` is 1 (mu-law), every code bit is inverted first, and s and t are taken from the inverted code. `lin_o[12]` is the inverted sign. The magnitude is (((2t+33)·2^s) − 33) / 2, rounded down.
- R8: The frame counter advances by one at each fall of sync after a word, whether complete or short. It wraps from 12 back to 1.
- R9: For a complete word in frame 6 or 12, the eighth bit is stored in `sig_a_o` when `ab_sel_i` is 0, and in `sig_b_o` when it is 1. The other signaling latch keeps its value.
- R10: For a complete word in frame 6 or 12, the code is expanded with bit 0 forced to 0, and `half_step_o` is 1. In all other frames `half_step_o` is 0 and both signaling latches keep their values.
- R11: When `sf_align_i` is high at a clock edge, the next word is frame 1. This takes priority over advancing. A word that ends on that same edge still uses its old frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_sync_i | input | 1 | Receive word window, high while bits are valid |
| rx_data_i | input | 1 | Serial companded data, MSB first |
| ab_sel_i | input | 1 | Signaling latch select: 0 = SigA, 1 = SigB |
| sf_align_i | input | 1 | Superframe alignment, sets the next word to frame 1 |
| mu_law_i | input | 1 | Expansion law: 1 = mu-law, 0 = A-law |
| lin_o | output | 13 | Latched linear code, sign in bit 12 and magnitude below |
| half_step_o | output | 1 | Half-step offset request for signaling frames |
| sig_a_o | output | 1 | SigA signaling latch |
| sig_b_o | output | 1 | SigB signaling latch |

## Verification
The bench builds the block with its default parameters: 3 segment bits, 4 step bits, a 12-frame superframe and signaling frames 6 and 12. With these values a full superframe takes only a dozen short words. That puts both signaling frames, the wrap from 12 to 1, the realignment from mid-superframe and the A/B routing within reach of one short run. The stimulus alternates the two laws, and it includes the largest code of each law, short windows and windows with extra clocks.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    // Serial capture states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
    import pcm_rx_pkg::*;
#(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 sync_i,
    input  logic                 data_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 word_end_o,
    output logic                 word_done_o
);

    localparam int CNT_W = $clog2(WORD_BITS + 1);

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [WORD_BITS-1:0] sh_q;
    logic               take_bit;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // transitions: start, fill, abort, commit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sync_i) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (!sync_i)                              state_d = ST_IDLE;
                else if (cnt_q == CNT_W'(WORD_BITS - 1))  state_d = ST_FULL;
            end
            ST_FULL:  if (!sync_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign take_bit = sync_i && (state_q != ST_FULL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (take_bit) begin
                sh_q  <= {sh_q[WORD_BITS-2:0], data_i};
                cnt_q <= (state_q == ST_IDLE) ? CNT_W'(1) : cnt_q + CNT_W'(1);
            end else if (!sync_i) begin
                cnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        word_o      = sh_q;
        word_end_o  = (state_q != ST_IDLE) && !sync_i;
        word_done_o = (state_q == ST_FULL) && !sync_i;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_W'(WORD_BITS));

    // R3
    full_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FULL) |-> (cnt_q == CNT_W'(WORD_BITS)));

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !sync_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/pcm_rx_frame_ctr.sv
module pcm_rx_frame_ctr #(
    parameter int FRAMES      = 12,
    parameter int SIG_FRAME_A = 6,
    parameter int SIG_FRAME_B = 12
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic word_end_i,
    input  logic align_i,
    output logic sig_frame_o
);

    localparam int FW = $clog2(FRAMES + 1);

    logic [FW-1:0] frame_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              frame_q <= FW'(1);
        else if (align_i)                         frame_q <= FW'(1);
        else if (word_end_i) begin
            if (frame_q == FW'(FRAMES))           frame_q <= FW'(1);
            else                                  frame_q <= frame_q + FW'(1);
        end
    end

    always_comb begin
        sig_frame_o = (frame_q == FW'(SIG_FRAME_A)) || (frame_q == FW'(SIG_FRAME_B));
    end

    // R8
    frame_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_q >= FW'(1)) && (frame_q <= FW'(FRAMES)));

    // R11
    align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        align_i |=> (frame_q == FW'(1)));

    // R8
    frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!align_i && !word_end_i) |=> $stable(frame_q));

endmodule

// File: rtl/pcm_rx_expand.sv
module pcm_rx_expand #(
    parameter int SEG_BITS  = 3,
    parameter int STEP_BITS = 4
) (
    input  logic [SEG_BITS+STEP_BITS:0]                  code_i,
    input  logic                                         mu_i,
    output logic [((1<<SEG_BITS)-1)+STEP_BITS+1:0]       lin_o
);

    localparam int WORD_BITS = 1 + SEG_BITS + STEP_BITS;
    localparam int MAG_BITS  = ((1 << SEG_BITS) - 1) + STEP_BITS + 1;
    localparam int HALF_BIAS = (1 << STEP_BITS) + 1;

    logic [WORD_BITS-1:0]  c;
    logic [SEG_BITS-1:0]   seg;
    logic [SEG_BITS-1:0]   seg_m1;
    logic [STEP_BITS-1:0]  step;
    logic [STEP_BITS+1:0]  mant;
    logic [MAG_BITS-1:0]   shifted;
    logic [MAG_BITS-1:0]   mag;

    always_comb begin
        c       = mu_i ? ~code_i : code_i;
        seg     = c[WORD_BITS-2:STEP_BITS];
        step    = c[STEP_BITS-1:0];
        seg_m1  = seg - SEG_BITS'(1);
        mant    = {1'b1, step, 1'b1};
        shifted = MAG_BITS'(mant) << seg_m1;
        if (seg == '0) begin
            mag = mu_i ? MAG_BITS'(step) : MAG_BITS'({step, 1'b1});
        end else begin
            mag = mu_i ? (shifted - MAG_BITS'(HALF_BIAS)) : shifted;
        end
        lin_o = {c[WORD_BITS-1], mag};
    end

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
    parameter int SEG_BITS    = 3,
    parameter int STEP_BITS   = 4,
    parameter int FRAMES      = 12,
    parameter int SIG_FRAME_A = 6,
    parameter int SIG_FRAME_B = 12
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        rx_sync_i,
    input  logic        rx_data_i,
    input  logic        ab_sel_i,
    input  logic        sf_align_i,
    input  logic        mu_law_i,
    output logic [((1<<SEG_BITS)-1)+STEP_BITS+1:0] lin_o,
    output logic        half_step_o,
    output logic        sig_a_o,
    output logic        sig_b_o
);

    localparam int WORD_BITS = 1 + SEG_BITS + STEP_BITS;
    localparam int LIN_BITS  = ((1 << SEG_BITS) - 1) + STEP_BITS + 2;

    logic [WORD_BITS-1:0] word;
    logic                 word_end;
    logic                 word_done;
    logic                 sig_frame;
    logic [WORD_BITS-1:0] code_eff;
    logic [LIN_BITS-1:0]  lin_d;
    logic [LIN_BITS-1:0]  lin_q;
    logic                 half_q, sig_a_q, sig_b_q;

    pcm_rx_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sync_i      (rx_sync_i),
        .data_i      (rx_data_i),
        .word_o      (word),
        .word_end_o  (word_end),
        .word_done_o (word_done)
    );

    pcm_rx_frame_ctr #(
        .FRAMES      (FRAMES),
        .SIG_FRAME_A (SIG_FRAME_A),
        .SIG_FRAME_B (SIG_FRAME_B)
    ) u_frame (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .word_end_i  (word_end),
        .align_i     (sf_align_i),
        .sig_frame_o (sig_frame)
    );

    // robbed bit forced to zero in signaling frames
    always_comb begin
        code_eff = sig_frame ? {word[WORD_BITS-1:1], 1'b0} : word;
    end

    pcm_rx_expand #(.SEG_BITS(SEG_BITS), .STEP_BITS(STEP_BITS)) u_exp (
        .code_i (code_eff),
        .mu_i   (mu_law_i),
        .lin_o  (lin_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lin_q   <= '0;
            half_q  <= 1'b0;
            sig_a_q <= 1'b0;
            sig_b_q <= 1'b0;
        end else if (word_done) begin
            lin_q  <= lin_d;
            half_q <= sig_frame;
            if (sig_frame) begin
                if (ab_sel_i) sig_b_q <= word[0];
                else          sig_a_q <= word[0];
            end
        end
    end

    always_comb begin
        lin_o       = lin_q;
        half_step_o = half_q;
        sig_a_o     = sig_a_q;
        sig_b_o     = sig_b_q;
    end

    // R5
    lin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !word_done |=> $stable(lin_o));

    // R10
    half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !word_done |=> $stable(half_step_o));

    // R9
    sig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(word_done && sig_frame) |=> $stable({sig_a_o, sig_b_o}));

    // R10
    half_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_done && sig_frame) |=> half_step_o);

    // R9
    sig_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_done && sig_frame && ab_sel_i) |=> $stable(sig_a_o));

endmodule

// File: tb/pcm_rx_deser_tb.sv
module pcm_rx_deser_tb;

    typedef struct {
        logic [12:0] lin;
        logic        half;
        logic        a;
        logic        b;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        data = 1'b0;
    logic        ab = 1'b0;
    logic        align = 1'b0;
    logic        mu = 1'b0;
    logic [12:0] lin;
    logic        half, sa, sb;

    int checks = 0;
    int errors = 0;

    exp_t q[$];
    event chk_ev;

    // model state
    logic [12:0] m_lin = '0;
    logic        m_half = 1'b0, m_a = 1'b0, m_b = 1'b0;
    int          m_frame = 1;

    always #5 clk = ~clk;

    pcm_rx_deser u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rx_sync_i   (sync),
        .rx_data_i   (data),
        .ab_sel_i    (ab),
        .sf_align_i  (align),
        .mu_law_i    (mu),
        .lin_o       (lin),
        .half_step_o (half),
        .sig_a_o     (sa),
        .sig_b_o     (sb)
    );

    function automatic logic [12:0] ref_lin(logic [7:0] code, logic is_mu);
        logic [7:0] c;
        int s, t, mag;
        c = is_mu ? ~code : code;
        s = int'(c[6:4]);
        t = int'(c[3:0]);
        if (is_mu) mag = (((2*t + 33) << s) - 33) >> 1;
        else       mag = (s == 0) ? (2*t + 1) : ((2*t + 33) << (s - 1));
        return {c[7], 12'(mag)};
    endfunction

    task automatic push_model(string tag);
        exp_t e;
        e.lin = m_lin; e.half = m_half; e.a = m_a; e.b = m_b; e.tag = tag;
        q.push_back(e);
        ->chk_ev;
    endtask

    // driver: one sync window of nbits clocks, then sync low for one edge
    task automatic send_word(logic [7:0] w, int nbits, logic law, logic sel,
                             logic do_align, string tag);
        logic       sigf;
        logic [7:0] c;
        mu = law;
        ab = sel;
        for (int i = 0; i < nbits; i++) begin
            sync = 1'b1;
            data = (i < 8) ? w[7-i] : 1'b1;
            @(negedge clk);
        end
        sync  = 1'b0;
        data  = 1'b0;
        align = do_align;
        @(negedge clk);
        align = 1'b0;
        if (nbits >= 8) begin
            sigf   = (m_frame == 6) || (m_frame == 12);
            c      = sigf ? {w[7:1], 1'b0} : w;
            m_lin  = ref_lin(c, law);
            m_half = sigf;
            if (sigf) begin
                if (sel) m_b = w[0];
                else     m_a = w[0];
            end
        end
        m_frame = do_align ? 1 : ((m_frame == 12) ? 1 : m_frame + 1);
        push_model(tag);
    endtask

    // monitor: pop expected items and compare
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (lin !== e.lin || half !== e.half || sa !== e.a || sb !== e.b) begin
                    errors++;
                    $display("FAIL %s: lin=%h half=%b a=%b b=%b expected lin=%h half=%b a=%b b=%b",
                             e.tag, lin, half, sa, sb, e.lin, e.half, e.a, e.b);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs at reset
        push_model("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_model("R1 after release");
        @(negedge clk);

        // R2 R6 R7 R8 R9 R10: a full superframe, alternating laws
        for (int f = 1; f <= 12; f++) begin
            logic [7:0] w;
            w = 8'(8'h35 + f * 8'h1D) | 8'h01;
            send_word(w, 8, f[0], (f == 12), 1'b0,
                      (f == 6 || f == 12) ? "R9 R10 signaling frame" :
                      (f[0] ? "R2 R7 mu-law word" : "R2 R6 A-law word"));
            @(negedge clk);
        end

        // R8: wrap back to frame 1, no half step
        send_word(8'h7F, 8, 1'b0, 1'b0, 1'b0, "R6 R8 A-law top code after wrap");
        // R7: mu-law largest magnitude
        send_word(8'h00, 8, 1'b1, 1'b0, 1'b0, "R7 mu-law top code");
        // R4: short window discarded
        send_word(8'h12, 5, 1'b0, 1'b0, 1'b0, "R4 short window");
        // R3: extra clocks ignored
        send_word(8'hA6, 11, 1'b0, 1'b0, 1'b0, "R3 extra clocks");
        // R5: hold through idle cycles
        repeat (6) @(negedge clk);
        push_model("R5 hold while idle");
        @(negedge clk);
        // frame 5 now; R11 realign on this word's end
        send_word(8'h5B, 8, 1'b1, 1'b0, 1'b1, "R11 word ending with align");
        for (int f = 1; f <= 6; f++) begin
            send_word(8'(8'hC1 + f * 8'h0B), 8, 1'b0, 1'b1, 1'b0,
                      (f == 6) ? "R11 R9 R10 frame 6 after align, SigB" :
                                 "R11 R10 non-signaling frame after align");
        end
        // R9: SigA clear in frame 12 path via second superframe half
        for (int f = 7; f <= 12; f++) begin
            send_word(8'h80 | 8'(f), 8, 1'b1, 1'b0, 1'b0,
                      (f == 12) ? "R9 R10 frame 12 SigA" : "R8 R10 plain frame");
        end
        // R10: frame 1 after signaling clears the half step
        send_word(8'hF0, 8, 1'b1, 1'b1, 1'b0, "R10 half step cleared");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule